// File: doc/BRIEF.md
# Segment Carryover Offset Adder

This block steps an 8-bit offset register, such as an instruction pointer or a stack pointer, by a signed 8-bit amount. When the offset wraps, the carry or borrow can spill into an 8-bit segment register. The segment and the offset together form a 16-bit byte address: the segment is the high byte and the offset is the low byte. The arithmetic is purely combinational. The new offset, the new segment and the joined address all appear in the same cycle as the inputs.

Each segment has its own carry-enable flag, and a small registered store keeps these flags. Software-visible instructions can switch a segment's carry on or off at run time, using a set strobe and a clear strobe that name a segment index. After reset the code segment (index 0) carries and the stack segment (index 1) does not. For each step, a select input chooses which segment's flag controls the adder.

Top module: `segcarry_top`

## Requirements
- R1: `offset_out` always equals `offset_in` plus `addend` read as a signed two's-complement byte, modulo 256.
- R2: With carry on, if a non-negative addend (bit 7 clear) makes the offset wrap past 255, then `segment_out` is `segment_in` + 1.
- R3: With carry on, if a negative addend (bit 7 set) makes the offset go below 0, then `segment_out` is `segment_in` - 1.
- R4: If the offset does not wrap, `segment_out` equals `segment_in`, even with carry on.
- R5: With carry off for the selected segment, `segment_out` equals `segment_in`, whatever the offset does.
- R6: The segment wraps modulo 256 (0xFF+1 gives 0x00, 0x00-1 gives 0xFF) and no error is flagged.
- R7: During and right after reset, `carry_flags` is 2'b01: bit 0 (code segment) is on and bit 1 (stack segment) is off.
- R8: A high `cfg_set` turns on flag `cfg_sel` at the next rising edge and leaves every other flag unchanged.
- R9: A high `cfg_clr` turns off flag `cfg_sel` at the next rising edge. When `cfg_set` and `cfg_clr` are both high, the clear wins.
- R10: If neither strobe is high, every flag keeps its value across the edge.
- R11: `addr_out` equals {`segment_out`, `offset_out`}, with the segment in bits 15:8.
- R12: `carry_on` shows the current flag of segment `add_sel`, and that flag is the one that controls the adder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag store |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_set | input | 1 | Turn on carry for segment `cfg_sel` |
| cfg_clr | input | 1 | Turn off carry for segment `cfg_sel`; wins over set |
| cfg_sel | input | 1 | Segment index that the strobes act on |
| add_sel | input | 1 | Segment index whose flag controls the adder |
| offset_in | input | 8 | Current offset |
| segment_in | input | 8 | Current segment |
| addend | input | 8 | Signed step |
| offset_out | output | 8 | Stepped offset |
| segment_out | output | 8 | Segment after carry or borrow |
| addr_out | output | 16 | Joined byte address {segment, offset} |
| carry_on | output | 1 | Flag in force for this step |
| carry_flags | output | 2 | All carry-enable flags |

## Verification
The bench builds the block with its defaults: 8-bit data, two segments, and reset flags 2'b01. With these values a single step can reach both wrap points, the -128 and +127 extremes of the addend, and the wrap of the segment itself. Two segments are enough to show that a strobe touches only the selected flag, that one segment carries while the other does not, and that a clear wins over a simultaneous set.

// File: rtl/segcarry_pkg.sv
package segcarry_pkg;

    localparam int SEG_CODE  = 0;
    localparam int SEG_STACK = 1;

    typedef struct packed {
        logic up;
        logic down;
    } wrap_t;

endpackage

// File: rtl/seg_offset_adder.sv
module seg_offset_adder
    import segcarry_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         carry_en,
    input  logic [W-1:0] offset_in,
    input  logic [W-1:0] segment_in,
    input  logic [W-1:0] addend,
    output logic [W-1:0] offset_out,
    output logic [W-1:0] segment_out
);

    localparam int SUM_W = W + 1;

    logic [SUM_W-1:0] raw_sum;
    wrap_t            wrap;

    assign raw_sum = {1'b0, offset_in} + {1'b0, addend};

    always_comb begin
        // unsigned carry out with a non-negative step means overflow;
        // no carry out with a negative step means the result went below zero
        wrap.up     = ~addend[W-1] &  raw_sum[W];
        wrap.down   =  addend[W-1] & ~raw_sum[W];
        offset_out  = raw_sum[W-1:0];
        segment_out = segment_in;
        if (carry_en && wrap.up) begin
            segment_out = segment_in + W'(1);
        end else if (carry_en && wrap.down) begin
            segment_out = segment_in - W'(1);
        end
    end

endmodule

// File: rtl/seg_carry_flags.sv
module seg_carry_flags #(
    parameter int              NSEG        = 2,
    parameter int              SEL_W       = 1,
    parameter logic [NSEG-1:0] RESET_FLAGS = 2'b01
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_set,
    input  logic             cfg_clr,
    input  logic [SEL_W-1:0] cfg_sel,
    output logic [NSEG-1:0]  flags_q
);

    typedef struct packed {
        logic [NSEG-1:0] en;
    } flag_state_t;

    flag_state_t state_d;
    flag_state_t state_q;
    logic [NSEG-1:0] hit;

    for (genvar g = 0; g < NSEG; g++) begin : g_hit
        assign hit[g] = (cfg_sel == SEL_W'(g));
    end

    always_comb begin
        state_d = state_q;
        for (int i = 0; i < NSEG; i++) begin
            if (hit[i] && cfg_clr) begin
                state_d.en[i] = 1'b0;
            end else if (hit[i] && cfg_set) begin
                state_d.en[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.en <= RESET_FLAGS;
        end else begin
            state_q <= state_d;
        end
    end

    assign flags_q = state_q.en;

    // R7: flags hold reset values one edge after reset was seen low
    a_r7_reset_value: assert property (@(posedge clk)
        !rst_n |=> flags_q == RESET_FLAGS);

    // R8: a set without a clear turns the selected flag on
    a_r8_set: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_set && !cfg_clr) |=> flags_q[$past(cfg_sel)]);

    // R9: a clear always turns the selected flag off
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_clr |=> !flags_q[$past(cfg_sel)]);

    // R10: with no strobe the flags keep their value
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_set && !cfg_clr) |=> $stable(flags_q));

endmodule

// File: rtl/segcarry_top.sv
module segcarry_top #(
    parameter int              W           = 8,
    parameter int              NSEG        = 2,
    parameter logic [NSEG-1:0] RESET_FLAGS = 2'b01,
    localparam int             SEL_W       = (NSEG > 1) ? $clog2(NSEG) : 1,
    localparam int             ADDR_W      = 2 * W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_set,
    input  logic              cfg_clr,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [SEL_W-1:0]  add_sel,
    input  logic [W-1:0]      offset_in,
    input  logic [W-1:0]      segment_in,
    input  logic [W-1:0]      addend,
    output logic [W-1:0]      offset_out,
    output logic [W-1:0]      segment_out,
    output logic [ADDR_W-1:0] addr_out,
    output logic              carry_on,
    output logic [NSEG-1:0]   carry_flags
);

    seg_carry_flags #(
        .NSEG        (NSEG),
        .SEL_W       (SEL_W),
        .RESET_FLAGS (RESET_FLAGS)
    ) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_set (cfg_set),
        .cfg_clr (cfg_clr),
        .cfg_sel (cfg_sel),
        .flags_q (carry_flags)
    );

    assign carry_on = carry_flags[add_sel];

    seg_offset_adder #(
        .W (W)
    ) u_adder (
        .carry_en    (carry_on),
        .offset_in   (offset_in),
        .segment_in  (segment_in),
        .addend      (addend),
        .offset_out  (offset_out),
        .segment_out (segment_out)
    );

    assign addr_out = {segment_out, offset_out};

    // R1: offset moves by the signed step, modulo 2**W
    a_r1_offset_step: assert property (@(posedge clk) disable iff (!rst_n)
        W'(offset_out - offset_in) == addend);

    // R2: upward wrap with carry on bumps the segment
    a_r2_carry_up: assert property (@(posedge clk) disable iff (!rst_n)
        (carry_on && !addend[W-1] && offset_out < offset_in)
        |-> segment_out == W'(segment_in + W'(1)));

    // R3: downward wrap with carry on drops the segment
    a_r3_borrow_down: assert property (@(posedge clk) disable iff (!rst_n)
        (carry_on && addend[W-1] && offset_out > offset_in)
        |-> segment_out == W'(segment_in - W'(1)));

    // R4: the segment never moves by more than one
    a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (segment_out == segment_in) ||
        (segment_out == W'(segment_in + W'(1))) ||
        (segment_out == W'(segment_in - W'(1))));

    // R5: carry off leaves the segment alone
    a_r5_carry_off: assert property (@(posedge clk) disable iff (!rst_n)
        !carry_on |-> segment_out == segment_in);

    // R11: address joins segment above offset
    a_r11_address: assert property (@(posedge clk) disable iff (!rst_n)
        addr_out[ADDR_W-1:W] == segment_out && addr_out[W-1:0] == offset_out);

endmodule

// File: tb/segcarry_top_bench.sv
`timescale 1ns/1ps
module segcarry_top_bench;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_set = 1'b0;
    logic         cfg_clr = 1'b0;
    logic [0:0]   cfg_sel = '0;
    logic [0:0]   add_sel = '0;
    logic [7:0]   offset_in = '0;
    logic [7:0]   segment_in = '0;
    logic [7:0]   addend = '0;
    logic [7:0]   offset_out;
    logic [7:0]   segment_out;
    logic [15:0]  addr_out;
    logic         carry_on;
    logic [1:0]   carry_flags;

    int runs = 0;
    int fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    segcarry_top u_segcarry_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_set     (cfg_set),
        .cfg_clr     (cfg_clr),
        .cfg_sel     (cfg_sel),
        .add_sel     (add_sel),
        .offset_in   (offset_in),
        .segment_in  (segment_in),
        .addend      (addend),
        .offset_out  (offset_out),
        .segment_out (segment_out),
        .addr_out    (addr_out),
        .carry_on    (carry_on),
        .carry_flags (carry_flags)
    );

    // {add_sel, offset, segment, addend, expected offset, expected segment}
    localparam int NV = 14;
    localparam logic [40:0] VEC [NV] = '{
        {1'b0, 8'h10, 8'h01, 8'h02, 8'h12, 8'h01},  // R1 R4 plain step
        {1'b0, 8'hFE, 8'h01, 8'h02, 8'h00, 8'h02},  // R2 wrap up
        {1'b0, 8'hFF, 8'h05, 8'h01, 8'h00, 8'h06},  // R2
        {1'b0, 8'h81, 8'h03, 8'h7F, 8'h00, 8'h04},  // R2 max positive
        {1'b0, 8'h00, 8'h05, 8'hFF, 8'hFF, 8'h04},  // R3 wrap down
        {1'b0, 8'h01, 8'h05, 8'hFE, 8'hFF, 8'h04},  // R3
        {1'b0, 8'h00, 8'h09, 8'h80, 8'h80, 8'h08},  // R3 max negative
        {1'b0, 8'h80, 8'h05, 8'h80, 8'h00, 8'h05},  // R4 -128 to zero
        {1'b0, 8'h7F, 8'h05, 8'h7F, 8'hFE, 8'h05},  // R4 no wrap
        {1'b0, 8'h40, 8'h07, 8'h00, 8'h40, 8'h07},  // R4 zero step
        {1'b0, 8'hFF, 8'hFF, 8'h01, 8'h00, 8'h00},  // R6 segment wraps up
        {1'b0, 8'h00, 8'h00, 8'hFF, 8'hFF, 8'hFF},  // R6 segment wraps down
        {1'b1, 8'hFE, 8'h02, 8'h02, 8'h00, 8'h02},  // R5 stack no carry
        {1'b1, 8'h00, 8'h02, 8'hFF, 8'hFF, 8'h02}   // R5 stack no borrow
    };

    task automatic check(input bit ok, input string req, input logic [15:0] act,
                         input logic [15:0] exp);
        runs++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic s, input logic [7:0] o, input logic [7:0] sg,
                         input logic [7:0] a);
        @(negedge clk);
        add_sel = s; offset_in = o; segment_in = sg; addend = a;
        #1;
    endtask

    task automatic strobe(input logic set, input logic clr, input logic sel);
        @(negedge clk);
        cfg_set = set; cfg_clr = clr; cfg_sel = sel;
        @(negedge clk);
        cfg_set = 1'b0; cfg_clr = 1'b0;
        #1;
    endtask

    initial begin
        #400000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", runs, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(carry_flags == 2'b01, "R7 in reset", {14'b0, carry_flags}, 16'h0001);
        rst_n = 1'b1;
        @(negedge clk);
        check(carry_flags == 2'b01, "R7 after reset", {14'b0, carry_flags}, 16'h0001);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][40], VEC[i][39:32], VEC[i][31:24], VEC[i][23:16]);
            check(offset_out == VEC[i][15:8], "R1 vector offset",
                  {8'h0, offset_out}, {8'h0, VEC[i][15:8]});
            check(segment_out == VEC[i][7:0], "R2 R3 R4 R5 R6 vector segment",
                  {8'h0, segment_out}, {8'h0, VEC[i][7:0]});
            check(addr_out == {VEC[i][7:0], VEC[i][15:8]}, "R11 joined address",
                  addr_out, {VEC[i][7:0], VEC[i][15:8]});
            check(carry_on == ~VEC[i][40], "R12 flag in force",
                  {15'b0, carry_on}, {15'b0, ~VEC[i][40]});
        end

        // R8: enable stack carry, code flag untouched
        strobe(1'b1, 1'b0, 1'b1);
        check(carry_flags == 2'b11, "R8 set stack", {14'b0, carry_flags}, 16'h0003);
        apply(1'b1, 8'hFE, 8'h02, 8'h04);
        check(segment_out == 8'h03 && offset_out == 8'h02, "R8 R12 stack now carries",
              {segment_out, offset_out}, 16'h0302);

        // R9: clear code carry, code wrap no longer moves segment
        strobe(1'b0, 1'b1, 1'b0);
        check(carry_flags == 2'b10, "R9 clear code", {14'b0, carry_flags}, 16'h0002);
        apply(1'b0, 8'hFF, 8'h01, 8'h01);
        check(segment_out == 8'h01 && carry_on == 1'b0, "R5 R12 code carry off",
              {segment_out, 7'b0, carry_on}, 16'h0100);

        // R9: simultaneous set and clear, clear wins
        strobe(1'b1, 1'b1, 1'b1);
        check(carry_flags == 2'b00, "R9 clear wins", {14'b0, carry_flags}, 16'h0000);

        // R10: idle edges keep flags
        strobe(1'b0, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        check(carry_flags == 2'b00, "R10 hold", {14'b0, carry_flags}, 16'h0000);

        // R8: re-enable code, stack stays off
        strobe(1'b1, 1'b0, 1'b0);
        check(carry_flags == 2'b01, "R8 set code only", {14'b0, carry_flags}, 16'h0001);

        // R7: reset mid-run restores defaults
        strobe(1'b1, 1'b0, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(carry_flags == 2'b01, "R7 async reset", {14'b0, carry_flags}, 16'h0001);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(carry_flags == 2'b01, "R7 reset again", {14'b0, carry_flags}, 16'h0001);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    end

endmodule